// File: doc/BRIEF.md
# Half-Precision to Unsigned Integer Converter

This block turns one IEEE 754 half-precision number into an unsigned integer of either a narrow (32-bit) or a wide (64-bit) width. It sits in an execution pipeline after operand read. It takes the whole source operand, but only the lowest 16 bits are converted. Alongside the integer it reports two status flags: invalid and precision (inexact). The caller supplies the exception mask for invalid. When that mask is set, an invalid conversion returns the all-ones indefinite code.

The rounding mode has two possible sources. An embedded two-bit field overrides the global two-bit field, but only when the operand came from a register and the embedded override is enabled. The wide result is produced only in 64-bit mode with a wide request. In every other case the narrow conversion is done and the upper bits are zero. A parameter chooses between a purely combinational path and a path with one output register stage. The default is the registered path.

Top module: `fp16_uconv`

## Requirements
- R1: Only bits [15:0] of `src_i` are converted. Changing any higher bit leaves all outputs unchanged.
- R2: The rounding code is `emb_rc_i` when `src_is_reg_i` and `emb_rnd_en_i` are both 1, and `glob_rc_i` otherwise. The codes are 00 nearest-even, 01 toward minus infinity, 10 toward plus infinity and 11 toward zero.
- R3: The conversion is wide (64-bit) only when `long_mode_i` and `wide_req_i` are both 1. Otherwise it is narrow (32-bit), and `res_o[63:32]` is 0.
- R4: A finite non-negative input with no fractional part returns its exact integer value, with both flags clear.
- R5: A finite input with a nonzero fractional part is rounded by the selected code and sets `prec_o`, unless the result is invalid.
- R6: An exponent field of all ones (infinity or NaN) sets `inv_o` and clears `prec_o`.
- R7: A negative finite input whose rounded magnitude is nonzero sets `inv_o`. If the rounded magnitude is 0, the result is 0 without `inv_o`, and `prec_o` is set if the input was inexact. Signed zero gives 0 with no flags.
- R8: On invalid with `inv_mask_i`=1, the result is all ones at the selected width. On invalid with `inv_mask_i`=0, the result is 0.
- R9: `inv_o` and `prec_o` are never both 1.
- R10: With `REG_OUT`=1, outputs reflect the inputs present at the previous rising clock edge, and reset (`rst_ni`=0) drives all outputs to 0.
- R11: Subnormal inputs are converted by value and give 0 or 1 depending on the rounding code, with `prec_o` set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the output register stage |
| rst_ni | input | 1 | Asynchronous active-low reset |
| src_i | input | SRC_W (128) | Source operand; bits [15:0] hold the half-precision value |
| wide_req_i | input | 1 | Requests a 64-bit result |
| long_mode_i | input | 1 | Core is in 64-bit mode |
| glob_rc_i | input | 2 | Global rounding code |
| emb_rc_i | input | 2 | Embedded rounding code |
| emb_rnd_en_i | input | 1 | Enables the embedded rounding override |
| src_is_reg_i | input | 1 | Operand came from a register |
| inv_mask_i | input | 1 | Invalid exception is masked |
| res_o | output | WIDE_W (64) | Unsigned integer result |
| inv_o | output | 1 | Invalid status flag |
| prec_o | output | 1 | Precision (inexact) status flag |

## Verification
Every one of the 65536 half-precision encodings is applied once, with random rounding sources, random width controls, random invalid mask and random upper operand bits. This sweep separates the normal, subnormal, zero, infinity and NaN classes, and both signs. Directed cases use ties (2.5 and -0.5) in each rounding code to separate nearest-even from the directed modes. They also show that the embedded field only wins for register operands with the enable set. Invalid NaN inputs under each width and mode combination separate the narrow and wide indefinite codes from the unmasked zero result. Random mixes after the sweep cover rounding-source and width combinations that the sweep did not reach.

// File: rtl/hcvt_pkg.sv
package hcvt_pkg;

   // Rounding codes; the binary values are the external encoding.
   typedef enum logic [1:0] {
      RM_NEAR = 2'b00,
      RM_DOWN = 2'b01,
      RM_UP   = 2'b10,
      RM_ZERO = 2'b11
   } rmode_e;

   typedef struct packed {
      logic sign;
      logic special;   // exponent all ones
      logic subnorm;   // exponent zero
   } hclass_t;

endpackage

// File: rtl/hcvt_ctl_sel.sv
module hcvt_ctl_sel
   import hcvt_pkg::*;
(
   input  logic [1:0] glob_rc_i,
   input  logic [1:0] emb_rc_i,
   input  logic       emb_rnd_en_i,
   input  logic       src_is_reg_i,
   input  logic       long_mode_i,
   input  logic       wide_req_i,
   output rmode_e     rmode_o,
   output logic       wide_o
);

   logic use_emb;

   always_comb begin
      use_emb = src_is_reg_i & emb_rnd_en_i;
      rmode_o = use_emb ? rmode_e'(emb_rc_i) : rmode_e'(glob_rc_i);
      // The width request only counts in 64-bit mode.
      wide_o  = long_mode_i & wide_req_i;
   end

endmodule

// File: rtl/hcvt_unpack.sv
module hcvt_unpack
   import hcvt_pkg::*;
#(
   parameter int EXP_W = 5,
   parameter int MAN_W = 10,
   localparam int HW   = 1 + EXP_W + MAN_W
) (
   input  logic [HW-1:0]    half_i,
   output hclass_t          cls_o,
   output logic [MAN_W:0]   sig_o,
   output logic [EXP_W-1:0] eff_exp_o
);

   logic [EXP_W-1:0] exp_f;
   logic [MAN_W-1:0] man_f;

   always_comb begin
      exp_f         = half_i[HW-2 -: EXP_W];
      man_f         = half_i[MAN_W-1:0];
      cls_o.sign    = half_i[HW-1];
      cls_o.special = &exp_f;
      cls_o.subnorm = ~|exp_f;
      // Subnormals: hidden bit clear, scale taken as exponent 1.
      sig_o         = {~cls_o.subnorm, man_f};
      eff_exp_o     = cls_o.subnorm ? EXP_W'(1) : exp_f;
   end

endmodule

// File: rtl/hcvt_align_round.sv
module hcvt_align_round
   import hcvt_pkg::*;
#(
   parameter int EXP_W  = 5,
   parameter int MAN_W  = 10,
   localparam int BIAS   = (1 << (EXP_W - 1)) - 1,
   localparam int FRAC_W = BIAS + MAN_W - 1,
   localparam int MAX_SH = (1 << EXP_W) - 3,
   localparam int FX_W   = MAN_W + 1 + MAX_SH,
   localparam int INT_W  = FX_W - FRAC_W,
   localparam int MAG_W  = INT_W + 1
) (
   input  logic [MAN_W:0]   sig_i,
   input  logic [EXP_W-1:0] eff_exp_i,
   input  logic             sign_i,
   input  rmode_e           rmode_i,
   output logic [MAG_W-1:0] mag_o,
   output logic             inexact_o
);

   logic [FX_W-1:0]  fx;
   logic [INT_W-1:0] ipart;
   logic             rbit;
   logic             sticky;
   logic             inc;

   // Fixed point with FRAC_W fraction bits: value = sig * 2^(eff_exp-1-FRAC_W)
   always_comb begin
      fx        = FX_W'(sig_i) << (eff_exp_i - EXP_W'(1));
      ipart     = fx[FX_W-1:FRAC_W];
      rbit      = fx[FRAC_W-1];
      sticky    = |fx[FRAC_W-2:0];
      inexact_o = rbit | sticky;
      unique case (rmode_i)
         RM_NEAR: inc = rbit & (sticky | ipart[0]);
         RM_DOWN: inc = sign_i & inexact_o;
         RM_UP:   inc = ~sign_i & inexact_o;
         default: inc = 1'b0;
      endcase
      mag_o = MAG_W'(ipart) + MAG_W'(inc);
   end

endmodule

// File: rtl/fp16_uconv.sv
module fp16_uconv
   import hcvt_pkg::*;
#(
   parameter int SRC_W    = 128,
   parameter int EXP_W    = 5,
   parameter int MAN_W    = 10,
   parameter int NARROW_W = 32,
   parameter int WIDE_W   = 64,
   parameter bit REG_OUT  = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [SRC_W-1:0]  src_i,
   input  logic              wide_req_i,
   input  logic              long_mode_i,
   input  logic [1:0]        glob_rc_i,
   input  logic [1:0]        emb_rc_i,
   input  logic              emb_rnd_en_i,
   input  logic              src_is_reg_i,
   input  logic              inv_mask_i,
   output logic [WIDE_W-1:0] res_o,
   output logic              inv_o,
   output logic              prec_o
);

   localparam int HW     = 1 + EXP_W + MAN_W;
   localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
   localparam int FRAC_W = BIAS + MAN_W - 1;
   localparam int MAX_SH = (1 << EXP_W) - 3;
   localparam int FX_W   = MAN_W + 1 + MAX_SH;
   localparam int MAG_W  = FX_W - FRAC_W + 1;
   localparam logic [WIDE_W-1:0] ONES_W = '1;
   localparam logic [WIDE_W-1:0] ONES_N = {{(WIDE_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

   // Elaboration-time parameter checks
   if (SRC_W < HW) begin : g_bad_src
      $error("fp16_uconv: SRC_W smaller than the half-precision field");
   end
   if (NARROW_W >= WIDE_W) begin : g_bad_w
      $error("fp16_uconv: NARROW_W must be below WIDE_W");
   end
   if (EXP_W < 3 || MAN_W < 1) begin : g_bad_fmt
      $error("fp16_uconv: format too small");
   end
   if (MAG_W > WIDE_W) begin : g_bad_mag
      $error("fp16_uconv: magnitude wider than the wide result");
   end

   logic [HW-1:0] half;
   logic          unused_hi;
   assign half      = src_i[HW-1:0];
   assign unused_hi = ^{1'b0, src_i};

   rmode_e           rmode;
   logic             wide;
   hclass_t          cls;
   logic [MAN_W:0]   sig;
   logic [EXP_W-1:0] eff_exp;
   logic [MAG_W-1:0] mag;
   logic             inexact;

   hcvt_ctl_sel u_ctl (
      .glob_rc_i    (glob_rc_i),
      .emb_rc_i     (emb_rc_i),
      .emb_rnd_en_i (emb_rnd_en_i),
      .src_is_reg_i (src_is_reg_i),
      .long_mode_i  (long_mode_i),
      .wide_req_i   (wide_req_i),
      .rmode_o      (rmode),
      .wide_o       (wide)
   );

   hcvt_unpack #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_unpack (
      .half_i    (half),
      .cls_o     (cls),
      .sig_o     (sig),
      .eff_exp_o (eff_exp)
   );

   hcvt_align_round #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_round (
      .sig_i     (sig),
      .eff_exp_i (eff_exp),
      .sign_i    (cls.sign),
      .rmode_i   (rmode),
      .mag_o     (mag),
      .inexact_o (inexact)
   );

   // Range checks: only generated when the magnitude can exceed a width.
   logic ovf_n, ovf_w;
   if (MAG_W > NARROW_W) begin : g_ovf_n
      assign ovf_n = |mag[MAG_W-1:NARROW_W];
   end else begin : g_no_ovf_n
      assign ovf_n = 1'b0;
   end
   if (MAG_W > WIDE_W) begin : g_ovf_w
      assign ovf_w = |mag[MAG_W-1:WIDE_W];
   end else begin : g_no_ovf_w
      assign ovf_w = 1'b0;
   end

   logic [WIDE_W-1:0] res_c;
   logic              inv_c, prec_c;

   always_comb begin
      inv_c  = cls.special | (cls.sign & (|mag)) | (wide ? ovf_w : ovf_n);
      prec_c = ~inv_c & ~cls.special & inexact;
      if (inv_c)
         res_c = inv_mask_i ? (wide ? ONES_W : ONES_N) : '0;
      else
         res_c = cls.sign ? '0 : WIDE_W'(mag);
   end

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            res_o  <= '0;
            inv_o  <= 1'b0;
            prec_o <= 1'b0;
         end else begin
            res_o  <= res_c;
            inv_o  <= inv_c;
            prec_o <= prec_c;
         end
      end
   end else begin : g_comb
      logic unused_clk;
      assign unused_clk = clk_i ^ rst_ni;
      assign res_o  = res_c;
      assign inv_o  = inv_c;
      assign prec_o = prec_c;
   end

endmodule

// File: rtl/fp16_uconv_chk.sv
module fp16_uconv_chk #(
   parameter int SRC_W    = 128,
   parameter int EXP_W    = 5,
   parameter int MAN_W    = 10,
   parameter int NARROW_W = 32,
   parameter int WIDE_W   = 64,
   parameter bit REG_OUT  = 1'b1
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic [SRC_W-1:0]  src_i,
   input logic              wide_req_i,
   input logic              long_mode_i,
   input logic              inv_mask_i,
   input logic [WIDE_W-1:0] res_o,
   input logic              inv_o,
   input logic              prec_o
);

   localparam int HW = 1 + EXP_W + MAN_W;
   localparam logic [WIDE_W-1:0] ONES_N = {{(WIDE_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

   logic          armed;
   logic [HW-1:0] q_half;
   logic          q_wide, q_mask;
   logic          unused_src;
   assign unused_src = ^{1'b0, src_i};

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) armed <= 1'b0;
      else         armed <= 1'b1;
   end

   if (REG_OUT) begin : g_q
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            q_half <= '0;
            q_wide <= 1'b0;
            q_mask <= 1'b0;
         end else begin
            q_half <= src_i[HW-1:0];
            q_wide <= long_mode_i & wide_req_i;
            q_mask <= inv_mask_i;
         end
      end
   end else begin : g_d
      assign q_half = src_i[HW-1:0];
      assign q_wide = long_mode_i & wide_req_i;
      assign q_mask = inv_mask_i;
   end

   logic q_special, q_sign;
   assign q_special = &q_half[HW-2 -: EXP_W];
   assign q_sign    = q_half[HW-1];

   p_flags_excl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed)
      !(inv_o && prec_o));

   p_special_inv_r6: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed)
      q_special |-> (inv_o && !prec_o));

   p_neg_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed)
      (q_sign && !inv_o) |-> (res_o == '0));

   p_mask_ones_r8: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed)
      (inv_o && q_mask) |-> (res_o == (q_wide ? {WIDE_W{1'b1}} : ONES_N)));

   p_unmask_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed)
      (inv_o && !q_mask) |-> (res_o == '0));

   p_narrow_hi_r3: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed)
      !q_wide |-> (res_o[WIDE_W-1:NARROW_W] == '0));

endmodule

bind fp16_uconv fp16_uconv_chk #(
   .SRC_W(SRC_W), .EXP_W(EXP_W), .MAN_W(MAN_W),
   .NARROW_W(NARROW_W), .WIDE_W(WIDE_W), .REG_OUT(REG_OUT)
) u_chk (.*);

// File: tb/sim_fp16_uconv.sv
module sim_fp16_uconv;

   localparam int CLK_PERIOD = 10;

   logic         clk_i = 1'b0;
   logic         rst_ni;
   logic [127:0] src_i;
   logic         wide_req_i, long_mode_i, emb_rnd_en_i, src_is_reg_i, inv_mask_i;
   logic [1:0]   glob_rc_i, emb_rc_i;
   logic [63:0]  res_o;
   logic         inv_o, prec_o;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk_i = ~clk_i;

   fp16_uconv u0 (.*);

   task automatic chk(input string tag, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   // Reference conversion computed with real arithmetic from the requirements.
   task automatic ref_conv(input logic [15:0] h, input logic [1:0] rm,
                           input bit wide, input bit mask,
                           output logic [63:0] r, output bit inv, output bit prec,
                           output string tag);
      int  e, m, sig, k;
      real v, fl, rr, d;
      e = int'(h[14:10]);
      m = int'(h[9:0]);
      inv = 0; prec = 0; r = '0; rr = 0.0;
      if (e == 31) begin
         inv = 1; tag = "R6";
      end else begin
         sig = (e == 0) ? m : m + 1024;
         k   = ((e == 0) ? 1 : e) - 25;
         v   = real'(sig);
         if (k > 0) for (int i = 0; i < k; i++) v = v * 2.0;
         else       for (int i = 0; i < -k; i++) v = v / 2.0;
         if (h[15]) v = -v;
         fl = $floor(v);
         case (rm)
            2'b00: begin
               d = v - fl;
               if (d > 0.5) rr = fl + 1.0;
               else if (d == 0.5) rr = ($floor(fl / 2.0) * 2.0 == fl) ? fl : fl + 1.0;
               else rr = fl;
            end
            2'b01: rr = fl;
            2'b10: rr = $ceil(v);
            default: rr = (v < 0.0) ? $ceil(v) : fl;
         endcase
         if (h[15])        tag = "R7";
         else if (e == 0 && m != 0) tag = "R11";
         else if (rr != v) tag = "R5";
         else              tag = "R4";
         if (rr < 0.0 || rr > 4294967295.0) inv = 1;
         else begin
            r    = 64'($rtoi(rr));
            prec = (rr != v);
         end
      end
      if (inv) begin
         prec = 0;
         r = mask ? (wide ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0000_0000_FFFF_FFFF) : 64'h0;
      end
   endtask

   task automatic apply(input logic [127:0] s, input bit wr, input bit lm,
                        input logic [1:0] g, input logic [1:0] em, input bit en,
                        input bit rg, input bit mask, input string force_tag);
      logic [63:0] er;
      bit          ei, ep, wide;
      logic [1:0]  rm;
      string       tag;
      @(negedge clk_i);
      src_i = s; wide_req_i = wr; long_mode_i = lm; glob_rc_i = g; emb_rc_i = em;
      emb_rnd_en_i = en; src_is_reg_i = rg; inv_mask_i = mask;
      wide = lm & wr;                       // R3
      rm   = (rg & en) ? em : g;            // R2
      ref_conv(s[15:0], rm, wide, mask, er, ei, ep, tag);
      if (force_tag != "") tag = force_tag;
      @(posedge clk_i);
      #1;
      chk(ei ? "R8" : tag, "res", res_o, er);
      chk(tag, "inv", 64'(inv_o), 64'(ei));
      chk(tag, "prec", 64'(prec_o), 64'(ep));
      chk("R9", "flag_excl", 64'(inv_o & prec_o), 64'h0);
   endtask

   function automatic logic [127:0] rnd_src(input logic [15:0] h);
      return {$urandom, $urandom, $urandom, $urandom[15:0], h};
   endfunction

   initial begin
      void'($urandom(32'd1729));
      rst_ni = 1'b0;
      src_i = '0; wide_req_i = 0; long_mode_i = 0; glob_rc_i = 0; emb_rc_i = 0;
      emb_rnd_en_i = 0; src_is_reg_i = 0; inv_mask_i = 0;
      repeat (3) @(posedge clk_i);
      #1;
      // R10: reset state
      chk("R10", "reset res", res_o, 64'h0);
      chk("R10", "reset inv", 64'(inv_o), 64'h0);
      chk("R10", "reset prec", 64'(prec_o), 64'h0);
      @(negedge clk_i);
      rst_ni = 1'b1;

      // R1: upper operand bits have no effect (value 3.0 = 0x4200)
      apply({112'h0, 16'h4200}, 0, 0, 2'b00, 2'b00, 0, 0, 1, "R1");
      apply({{112{1'b1}}, 16'h4200}, 0, 0, 2'b00, 2'b00, 0, 0, 1, "R1");
      apply({112'h5A5A_1234, 16'h4200}, 1, 1, 2'b01, 2'b10, 1, 1, 0, "R1");
      // R2: 2.5 (0x4100), global nearest vs embedded up
      apply({112'h0, 16'h4100}, 0, 0, 2'b00, 2'b10, 1, 0, 1, "R2");
      apply({112'h0, 16'h4100}, 0, 0, 2'b00, 2'b10, 1, 1, 1, "R2");
      apply({112'h0, 16'h4100}, 0, 0, 2'b00, 2'b10, 0, 1, 1, "R2");
      // R5: 2.5 and 3.5 in every code
      for (int c = 0; c < 4; c++) begin
         apply({112'h0, 16'h4100}, 0, 0, 2'(c), 2'b00, 0, 0, 1, "R5");
         apply({112'h0, 16'h4300}, 0, 0, 2'(c), 2'b00, 0, 0, 1, "R5");
      end
      // R7: -0.5 (0xB800) per code, -0.0, -1.0
      for (int c = 0; c < 4; c++)
         apply({112'h0, 16'hB800}, 0, 0, 2'(c), 2'b00, 0, 0, 1, "R7");
      apply({112'h0, 16'h8000}, 0, 0, 2'b00, 2'b00, 0, 0, 1, "R7");
      apply({112'h0, 16'hBC00}, 0, 0, 2'b11, 2'b00, 0, 0, 1, "R7");
      // R6 / R8 / R3: infinity and NaN under width and mask combinations
      apply({112'h0, 16'h7C00}, 1, 0, 2'b00, 2'b00, 0, 0, 1, "R3");
      apply({112'h0, 16'h7C00}, 1, 1, 2'b00, 2'b00, 0, 0, 1, "R3");
      apply({112'h0, 16'h7E00}, 0, 1, 2'b00, 2'b00, 0, 0, 1, "R8");
      apply({112'h0, 16'hFE01}, 1, 1, 2'b00, 2'b00, 0, 0, 0, "R8");
      // R4: largest finite, one, zero
      apply({112'h0, 16'h7BFF}, 1, 1, 2'b00, 2'b00, 0, 0, 1, "R4");
      apply({112'h0, 16'h3C00}, 0, 0, 2'b10, 2'b00, 0, 0, 1, "R4");
      apply({112'h0, 16'h0000}, 0, 0, 2'b10, 2'b00, 0, 0, 1, "R4");
      // R11: smallest and largest subnormal
      for (int c = 0; c < 4; c++) begin
         apply({112'h0, 16'h0001}, 0, 0, 2'(c), 2'b00, 0, 0, 1, "R11");
         apply({112'h0, 16'h03FF}, 0, 0, 2'(c), 2'b00, 0, 0, 1, "R11");
      end

      // Full sweep of every encoding with random controls
      for (int i = 0; i < 65536; i++)
         apply(rnd_src(16'(i)), 1'($urandom), 1'($urandom), 2'($urandom), 2'($urandom),
               1'($urandom), 1'($urandom), 1'($urandom), "");
      // Random mix
      for (int i = 0; i < 2000; i++)
         apply(rnd_src(16'($urandom)), 1'($urandom), 1'($urandom), 2'($urandom),
               2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), "");

      // R10: reset clears a nonzero output
      apply({112'h0, 16'h7BFF}, 0, 0, 2'b00, 2'b00, 0, 0, 1, "R10");
      rst_ni = 1'b0;
      #1;
      chk("R10", "async reset res", res_o, 64'h0);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk_i);
      if (!done) begin
         failures++;
         checks++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule